// File: doc/BRIEF.md
# Two-Preset Interval Timer

This block is a seconds-resolution countdown timer for a sequencing controller. A 2-bit command picks one of four actions on every clock cycle. Two command values load a fixed long interval (30 s by default) or a fixed short interval (3 s by default). A third value runs the countdown, and the fourth value freezes it. The block counts seconds from a one-cycle tick input that is high once per second. It does not generate that tick from the clock.

The controller applies a load command for a single cycle and then holds the run command. A single `done` output stays low while the loaded interval is still running down. Once the interval has expired, `done` stays high through any further run or stop cycles until the next load. The controller therefore never misses the expiry, even if it polls late.

Top module: `interval_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears `done` to 0 and the remaining count to 0. After reset, a single run cycle with no tick therefore raises `done`.
- R2: Command value 2'b01 loads the long interval (LONG_SECS, default 30) at the clock edge. It also clears `done` in that same edge, whatever state the timer was in before.
- R3: Command value 2'b10 loads the short interval (SHORT_SECS, default 3) at the clock edge. It also clears `done` in that same edge.
- R4: Command value 2'b11 is run. A run cycle with `secTick` high decrements the count by one, and the count saturates at 0. Exactly N ticks are needed after a load of N: after the Nth tick edge, `done` is still 0, and it becomes 1 at the next run edge.
- R5: A run cycle with `secTick` low leaves the count unchanged, so it never shortens the interval.
- R6: Command value 2'b00 is stop. It holds both the count and `done` unchanged, whatever `secTick` does.
- R7: Once `done` is 1, it stays 1 under run and stop commands until a load command is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| secTick | input | 1 | One-cycle pulse, once per second |
| cmd | input | 2 | 00 stop, 01 load long, 10 load short, 11 run |
| done | output | 1 | Interval elapsed flag; sticky until next load |

## Verification
A load clears `done` at the edge that samples it, so the bench checks `done` low one cycle after the load. A run edge that carries a tick changes the count at that edge. `done` follows one run edge after the count reaches zero. The bench therefore counts ticks exactly and checks that `done` is still 0 right after the final tick edge and becomes 1 after the next run edge. Each bench step drives inputs at the falling edge and samples 1 ns after the following rising edge, so every check reads the value settled by exactly one clock edge.

// File: rtl/ivtmr_pkg.sv
package ivtmr_pkg;

  typedef enum logic [1:0] {
    CMD_STOP       = 2'b00,
    CMD_LOAD_LONG  = 2'b01,
    CMD_LOAD_SHORT = 2'b10,
    CMD_RUN        = 2'b11
  } timerCmd_e;

  typedef struct packed {
    logic loadLong;
    logic loadShort;
    logic runActive;
    logic countEn;
  } timerStrobe_t;

endpackage

// File: rtl/ivtmr_ctrl.sv
module ivtmr_ctrl
  import ivtmr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   cmd,
  input  logic         secTick,
  output timerStrobe_t strb
);

  timerCmd_e cmdDec;

  always_comb begin
    cmdDec = timerCmd_e'(cmd);
    strb   = '0;
    unique case (cmdDec)
      CMD_LOAD_LONG:  strb.loadLong  = 1'b1;
      CMD_LOAD_SHORT: strb.loadShort = 1'b1;
      CMD_RUN: begin
        strb.runActive = 1'b1;
        strb.countEn   = secTick;
      end
      default: ;
    endcase
  end

  // R4: at most one action strobe per cycle; counting only while running
  assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadLong, strb.loadShort, strb.runActive}) &&
    (!strb.countEn || strb.runActive));

endmodule

// File: rtl/ivtmr_datapath.sv
module ivtmr_datapath
  import ivtmr_pkg::*;
#(
  parameter int LONG_SECS  = 30,
  parameter int SHORT_SECS = 3,
  parameter int CNT_W      = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  timerStrobe_t strb,
  output logic         done
);

  localparam logic [CNT_W-1:0] LONG_VAL  = CNT_W'(LONG_SECS);
  localparam logic [CNT_W-1:0] SHORT_VAL = CNT_W'(SHORT_SECS);

  logic [CNT_W-1:0] count;
  logic             countZero;
  logic             anyLoad;

  assign countZero = (count == '0);
  assign anyLoad   = strb.loadLong | strb.loadShort;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      done  <= 1'b0;
    end else if (strb.loadLong) begin
      count <= LONG_VAL;
      done  <= 1'b0;
    end else if (strb.loadShort) begin
      count <= SHORT_VAL;
      done  <= 1'b0;
    end else if (strb.runActive) begin
      done <= done | countZero;
      if (strb.countEn && !countZero) count <= count - CNT_W'(1);
    end
  end

  // R2: long load sets the count and clears done
  assert_long_load_R2: assert property (@(posedge clk) disable iff (rst)
    strb.loadLong |=> (count == LONG_VAL) && !done);

  // R3: short load sets the count and clears done
  assert_short_load_R3: assert property (@(posedge clk) disable iff (rst)
    strb.loadShort |=> (count == SHORT_VAL) && !done);

  // R4: ticked run decrements by one or stays at zero
  assert_tick_step_R4: assert property (@(posedge clk) disable iff (rst)
    strb.countEn && !anyLoad |=>
      (count == $past(count) - CNT_W'(1)) || ($past(count) == '0 && count == '0));

  // R4: count never exceeds the long preset
  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    count <= LONG_VAL);

  // R5: run without tick leaves the count alone
  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (rst)
    strb.runActive && !strb.countEn |=> $stable(count));

  // R6: stop freezes count and done
  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !anyLoad && !strb.runActive |=> $stable(count) && $stable(done));

  // R7: done is sticky until a load
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done && !anyLoad |=> done);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivtmr_pkg::*;
#(
  parameter int LONG_SECS  = 30,
  parameter int SHORT_SECS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       secTick,
  input  logic [1:0] cmd,
  output logic       done
);

  localparam int MAX_SECS = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS;
  localparam int CNT_W    = $clog2(MAX_SECS + 1);

  timerStrobe_t strb;

  ivtmr_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .secTick (secTick),
    .strb    (strb)
  );

  ivtmr_datapath #(
    .LONG_SECS  (MAX_SECS),
    .SHORT_SECS (SHORT_SECS),
    .CNT_W      (CNT_W)
  ) i_datapath (
    .clk  (clk),
    .rst  (rst),
    .strb (strb),
    .done (done)
  );

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       secTick = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       done;

  int testCount = 0;
  int failCount = 0;

  localparam logic [1:0] C_STOP  = 2'b00;
  localparam logic [1:0] C_LONG  = 2'b01;
  localparam logic [1:0] C_SHORT = 2'b10;
  localparam logic [1:0] C_RUN   = 2'b11;

  always #10 clk = ~clk;

  interval_timer i_interval_timer (
    .clk     (clk),
    .rst     (rst),
    .secTick (secTick),
    .cmd     (cmd),
    .done    (done)
  );

  task automatic step(input logic [1:0] c, input logic t);
    @(negedge clk);
    cmd = c;
    secTick = t;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic expv);
    testCount++;
    if (done !== expv) begin
      failCount++;
      $display("FAIL %s: done=%b expected=%b", req, done, expv);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  task automatic testReset();
    rst = 1'b1;
    step(C_STOP, 1'b0);
    step(C_RUN, 1'b1);
    check("R1 reset clears done", 1'b0);
    rst = 1'b0;
    step(C_RUN, 1'b0);
    check("R1 count zero after reset", 1'b1);
  endtask

  task automatic testLong();
    step(C_LONG, 1'b0);
    check("R2 long load clears done", 1'b0);
    for (int i = 0; i < 29; i++) step(C_RUN, 1'b1);
    check("R4 29 ticks not enough", 1'b0);
    for (int i = 0; i < 5; i++) step(C_RUN, 1'b0);
    check("R5 untick run no count", 1'b0);
    step(C_RUN, 1'b1);
    check("R4 done not yet on 30th tick edge", 1'b0);
    step(C_RUN, 1'b0);
    check("R4 done after 30 ticks", 1'b1);
    for (int i = 0; i < 4; i++) step(C_RUN, 1'b1);
    check("R7 done sticky under run", 1'b1);
    for (int i = 0; i < 3; i++) step(C_STOP, 1'b1);
    check("R6 stop holds done high", 1'b1);
  endtask

  task automatic testShortWithStop();
    step(C_SHORT, 1'b0);
    check("R3 short load clears done", 1'b0);
    step(C_RUN, 1'b1);
    step(C_RUN, 1'b1);
    for (int i = 0; i < 8; i++) step(C_STOP, 1'b1);
    check("R6 stop freezes count", 1'b0);
    step(C_RUN, 1'b0);
    check("R6 one second still remains", 1'b0);
    step(C_RUN, 1'b1);
    check("R4 done not yet on 3rd tick edge", 1'b0);
    step(C_RUN, 1'b0);
    check("R4 done after 3 ticks", 1'b1);
  endtask

  task automatic testReload();
    step(C_SHORT, 1'b0);
    step(C_RUN, 1'b1);
    step(C_LONG, 1'b0);
    check("R2 reload mid count clears done", 1'b0);
    for (int i = 0; i < 3; i++) step(C_RUN, 1'b1);
    step(C_RUN, 1'b0);
    check("R2 reload restored full 30", 1'b0);
    for (int i = 0; i < 27; i++) step(C_RUN, 1'b1);
    step(C_RUN, 1'b0);
    check("R2 reload expires after 30", 1'b1);
    step(C_SHORT, 1'b1);
    check("R3 short load clears high done", 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: done=%b expected=finished", done);
    finishRun();
  end

  initial begin
    testReset();
    testLong();
    testShortWithStop();
    testReload();
    finishRun();
  end

endmodule